// File: doc/BRIEF.md
# RGB Blink and Fade Sequencer

This block produces the automatic blink and fade envelope for one group of three LED channels (red, green, blue). A free-running frame timer, advanced by an oscillator tick, divides each blink cycle into 64 positions. Each channel has its own 6-bit light-up position and darken position inside that frame. It can ramp up linearly after lighting and ramp down linearly after darkening. The ramp lengths are chosen from fixed fractions of the frame. For every channel the block emits a 5-bit effective current code, which feeds the analog current DAC elsewhere on the chip.

With automatic operation off, each channel passes its target code straight through, gated only by its channel enable. A single-run mode stops the sequence after one full frame and holds the outputs dark. A second instance can follow the first: in follow mode it takes the frame position and the finished flag from the other instance's timer outputs instead of its own timer.

Top module: `rgb_fade_seq`

## Requirements
- R1: With `auto_en` low, each `code_o` channel equals its `target` code when its `ch_en` bit is 1 and 0 otherwise, and `tm_pos` stays at 0.
- R2: With `auto_en` high, `tm_pos` advances by one, wrapping 63 to 0, after every 2^(BASE_SHIFT+`period_sel`) cycles with `tick` high. While `tick` is low, `tm_pos` holds.
- R3: Period codes 6 and 7 are invalid and give the same position length as code 5.
- R4: A channel is lit for positions p where (p - on) mod 64 < (off - on) mod 64. When on equals off, the channel is dark for the whole frame.
- R5: Fade-in length L is selected by the 3-bit code as 0, 2, 4, 8, 16, 32, 48, 32 positions for codes 0..7. For the first L lit positions, at e = (p - on) mod 64, the code is floor(target*(e+1)/L). After that it is target.
- R6: Fade-out uses the same length table. Outside the lit window, at d = (p - off) mod 64 < L, the code is floor(target*(L-1-d)/L); otherwise it is 0. The lit window takes priority over a fade-out tail.
- R7: In automatic mode, a channel whose `ch_en` bit is 0 outputs 0.
- R8: In single-run mode, when position 63 completes, `tm_done` rises with `tm_pos` at 0. All codes then stay 0 until the configuration changes.
- R9: Any change of `auto_en` or `one_shot` clears `tm_done` and restarts the frame at position 0.
- R10: With `follow` high, the envelopes use `sync_pos_i` as the frame position and `sync_done_i` as the finished flag.
- R11: After reset, `tm_pos` is 0 and `tm_done` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Oscillator tick, one cycle wide |
| auto_en | input | 1 | Automatic blink/fade operation enable |
| one_shot | input | 1 | Run one frame, then stop dark |
| period_sel | input | 3 | Frame period select (position = 2^(BASE_SHIFT+code) ticks) |
| fin_sel | input | 3 | Fade-in length select |
| fout_sel | input | 3 | Fade-out length select |
| on_pos | input | 18 | Per-channel light-up positions, channel i at bits [6i+5:6i] |
| off_pos | input | 18 | Per-channel darken positions, channel i at bits [6i+5:6i] |
| target | input | 15 | Per-channel target codes, channel i at bits [5i+4:5i] |
| ch_en | input | 3 | Per-channel enable |
| follow | input | 1 | Use the other instance's timing |
| sync_pos_i | input | 6 | Frame position from the leading instance |
| sync_done_i | input | 1 | Finished flag from the leading instance |
| tm_pos | output | 6 | This instance's own frame position |
| tm_done | output | 1 | This instance's own single-run finished flag |
| code_o | output | 15 | Effective current codes, channel i at bits [5i+4:5i] |

## Verification
The embedded assertions check on every cycle the properties that can be stated without a reference model. The frame position only ever steps by one or returns to 0, and it holds while no tick arrives. The finished flag rises only at position 0 and holds until the configuration changes. A channel is dark when its positions coincide or its enable is low, and no channel code ever exceeds its target. The exact ramp values, the position length for each period code, the substitution for invalid codes, the frame count of a single run and the behaviour in follow mode can only be shown by the bench's scenarios. The bench sweeps positions through the follow inputs and times the running frame.

// File: rtl/rgbseq_pkg.sv
package rgbseq_pkg;
  localparam int POS_W  = 6;
  localparam int CODE_W = 5;
  localparam int SEL_W  = 3;
  localparam int LEN_W  = POS_W + 1;
  localparam int PROD_W = CODE_W + LEN_W;
  localparam int MAX_PERIOD = 5;

  // Ramp length in frame positions for a slope select code.
  function automatic logic [LEN_W-1:0] fade_len(input logic [SEL_W-1:0] sel);
    case (sel)
      3'd1:    return LEN_W'(2);
      3'd2:    return LEN_W'(4);
      3'd3:    return LEN_W'(8);
      3'd4:    return LEN_W'(16);
      3'd5:    return LEN_W'(32);
      3'd6:    return LEN_W'(48);
      3'd7:    return LEN_W'(32);
      default: return '0;
    endcase
  endfunction

  // floor(tgt*n/len) with the divisor fixed per select code.
  function automatic logic [CODE_W-1:0] fade_scale(input logic [CODE_W-1:0] tgt,
                                                   input logic [LEN_W-1:0] n,
                                                   input logic [SEL_W-1:0] sel);
    logic [PROD_W-1:0] p;
    logic [PROD_W-1:0] q;
    p = PROD_W'(tgt) * PROD_W'(n);
    case (sel)
      3'd1:      q = p >> 1;
      3'd2:      q = p >> 2;
      3'd3:      q = p >> 3;
      3'd4:      q = p >> 4;
      3'd5, 3'd7: q = p >> 5;
      3'd6:      q = p / PROD_W'(48);
      default:   q = '0;
    endcase
    return q[CODE_W-1:0];
  endfunction

  function automatic logic [CODE_W-1:0] env_level(input logic [POS_W-1:0] pos,
                                                  input logic [POS_W-1:0] on_p,
                                                  input logic [POS_W-1:0] off_p,
                                                  input logic [CODE_W-1:0] tgt,
                                                  input logic [SEL_W-1:0] fin,
                                                  input logic [SEL_W-1:0] fout);
    logic [POS_W-1:0] span, since_on, since_off;
    logic [LEN_W-1:0] lin, lout;
    span      = off_p - on_p;
    since_on  = pos - on_p;
    since_off = pos - off_p;
    lin  = fade_len(fin);
    lout = fade_len(fout);
    if (on_p == off_p) return '0;
    if (since_on < span) begin
      if (LEN_W'(since_on) < lin) return fade_scale(tgt, LEN_W'(since_on) + LEN_W'(1), fin);
      return tgt;
    end
    if (LEN_W'(since_off) < lout)
      return fade_scale(tgt, lout - LEN_W'(1) - LEN_W'(since_off), fout);
    return '0;
  endfunction
endpackage

// File: rtl/frame_timer.sv
module frame_timer
  import rgbseq_pkg::*;
#(
  parameter int BASE_SHIFT = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             auto_en,
  input  logic             one_shot,
  input  logic [SEL_W-1:0] period_sel,
  output logic [POS_W-1:0] pos_o,
  output logic             done_o
);
  localparam int SUB_W = BASE_SHIFT + MAX_PERIOD;

  logic [SUB_W-1:0] sub_q;
  logic [POS_W-1:0] pos_q;
  logic             done_q, en_q, os_q;
  logic [SEL_W-1:0] code_c;
  logic [SUB_W:0]   lim_wide;
  logic [SUB_W-1:0] sub_lim;
  logic             cfg_chg, pos_step, frame_end;

  assign code_c    = (period_sel > SEL_W'(MAX_PERIOD)) ? SEL_W'(MAX_PERIOD) : period_sel;
  assign lim_wide  = ((SUB_W + 1)'(1) << (BASE_SHIFT + int'(code_c))) - (SUB_W + 1)'(1);
  assign sub_lim   = lim_wide[SUB_W-1:0];
  assign cfg_chg   = (auto_en != en_q) || (one_shot != os_q);
  assign pos_step  = auto_en && !done_q && tick && (sub_q >= sub_lim);
  assign frame_end = pos_step && (pos_q == {POS_W{1'b1}}) && one_shot;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sub_q <= '0; pos_q <= '0; done_q <= 1'b0; en_q <= 1'b0; os_q <= 1'b0;
    end else begin
      en_q <= auto_en;
      os_q <= one_shot;
      if (cfg_chg || !auto_en) begin
        sub_q <= '0; pos_q <= '0; done_q <= 1'b0;
      end else if (pos_step) begin
        sub_q <= '0;
        pos_q <= pos_q + POS_W'(1);
        if (frame_end) done_q <= 1'b1;
      end else if (tick && !done_q) begin
        sub_q <= sub_q + SUB_W'(1);
      end
    end
  end

  assign pos_o  = pos_q;
  assign done_o = done_q;

  // R2
  pos_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pos_q != $past(pos_q)) |-> (pos_q == $past(pos_q) + POS_W'(1) || pos_q == '0));
  // R2
  tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !cfg_chg) |=> $stable(pos_q));
  // R8
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !cfg_chg) |=> done_q);
  // R8
  done_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) |-> (pos_q == '0));
endmodule

// File: rtl/env_chan.sv
module env_chan
  import rgbseq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [POS_W-1:0]  pos,
  input  logic [POS_W-1:0]  on_p,
  input  logic [POS_W-1:0]  off_p,
  input  logic [CODE_W-1:0] tgt,
  input  logic [SEL_W-1:0]  fin,
  input  logic [SEL_W-1:0]  fout,
  output logic [CODE_W-1:0] level
);
  assign level = env_level(pos, on_p, off_p, tgt, fin, fout);

  // R4
  dark_equal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (on_p == off_p) |-> (level == '0));
  // R5
  level_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    level <= tgt);
endmodule

// File: rtl/rgb_fade_seq.sv
module rgb_fade_seq
  import rgbseq_pkg::*;
#(
  parameter int NCH        = 3,
  parameter int BASE_SHIFT = 11
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    tick,
  input  logic                    auto_en,
  input  logic                    one_shot,
  input  logic [SEL_W-1:0]        period_sel,
  input  logic [SEL_W-1:0]        fin_sel,
  input  logic [SEL_W-1:0]        fout_sel,
  input  logic [NCH*POS_W-1:0]    on_pos,
  input  logic [NCH*POS_W-1:0]    off_pos,
  input  logic [NCH*CODE_W-1:0]   target,
  input  logic [NCH-1:0]          ch_en,
  input  logic                    follow,
  input  logic [POS_W-1:0]        sync_pos_i,
  input  logic                    sync_done_i,
  output logic [POS_W-1:0]        tm_pos,
  output logic                    tm_done,
  output logic [NCH*CODE_W-1:0]   code_o
);
  logic [POS_W-1:0] pos_eff;
  logic             done_eff;

  frame_timer #(.BASE_SHIFT(BASE_SHIFT)) u_timer (
    .clk(clk), .rst_n(rst_n), .tick(tick), .auto_en(auto_en),
    .one_shot(one_shot), .period_sel(period_sel),
    .pos_o(tm_pos), .done_o(tm_done)
  );

  assign pos_eff  = follow ? sync_pos_i  : tm_pos;
  assign done_eff = follow ? sync_done_i : tm_done;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic [CODE_W-1:0] lvl;
    logic [CODE_W-1:0] tgt_i;
    assign tgt_i = target[i*CODE_W +: CODE_W];

    env_chan u_env (
      .clk(clk), .rst_n(rst_n), .pos(pos_eff),
      .on_p(on_pos[i*POS_W +: POS_W]), .off_p(off_pos[i*POS_W +: POS_W]),
      .tgt(tgt_i), .fin(fin_sel), .fout(fout_sel), .level(lvl)
    );

    always_comb begin
      if (!ch_en[i])      code_o[i*CODE_W +: CODE_W] = '0;
      else if (!auto_en)  code_o[i*CODE_W +: CODE_W] = tgt_i;
      else if (done_eff)  code_o[i*CODE_W +: CODE_W] = '0;
      else                code_o[i*CODE_W +: CODE_W] = lvl;
    end

    // R7
    ch_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ch_en[i] |-> (code_o[i*CODE_W +: CODE_W] == '0));
    // R8
    done_dark_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (auto_en && done_eff) |-> (code_o[i*CODE_W +: CODE_W] == '0));
  end
endmodule

// File: tb/test_rgb_fade_seq.sv
module test_rgb_fade_seq;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 3;
  localparam int BS  = 1;

  logic clk = 0, rst_n = 0, tick = 0, auto_en = 0, one_shot = 0;
  logic [2:0] period_sel = 0, fin_sel = 0, fout_sel = 0;
  logic [17:0] on_pos = 0, off_pos = 0;
  logic [14:0] target = 0;
  logic [2:0] ch_en = 0;
  logic follow = 0, sync_done_i = 0;
  logic [5:0] sync_pos_i = 0;
  logic [5:0] tm_pos;
  logic tm_done;
  logic [14:0] code_o;
  int n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rgb_fade_seq #(.NCH(NCH), .BASE_SHIFT(BS)) i_rgb_fade_seq (
    .clk(clk), .rst_n(rst_n), .tick(tick), .auto_en(auto_en), .one_shot(one_shot),
    .period_sel(period_sel), .fin_sel(fin_sel), .fout_sel(fout_sel),
    .on_pos(on_pos), .off_pos(off_pos), .target(target), .ch_en(ch_en),
    .follow(follow), .sync_pos_i(sync_pos_i), .sync_done_i(sync_done_i),
    .tm_pos(tm_pos), .tm_done(tm_done), .code_o(code_o));

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int ramp_positions(input int s);
    int tbl[8] = '{0, 2, 4, 8, 16, 32, 48, 32};
    return tbl[s];
  endfunction

  // Expected code from the requirement text (R4, R5, R6).
  function automatic int model(input int p, input int on, input int off, input int t,
                               input int fi, input int fo);
    int win = (off - on + 64) % 64;
    int e = (p - on + 64) % 64;
    int d = (p - off + 64) % 64;
    int li = ramp_positions(fi);
    int lo = ramp_positions(fo);
    if (on == off) return 0;
    if (e < win) return (e < li) ? (t * (e + 1)) / li : t;
    if (d < lo) return (t * (lo - 1 - d)) / lo;
    return 0;
  endfunction

  function automatic int code_of(input int ch);
    return int'(code_o[ch*5 +: 5]);
  endfunction

  task automatic set_ch(input int ch, input int on, input int off, input int t);
    on_pos[ch*6 +: 6]  = 6'(on);
    off_pos[ch*6 +: 6] = 6'(off);
    target[ch*5 +: 5]  = 5'(t);
  endtask

  task automatic sweep(input string req, input int fi, input int fo);
    fin_sel = 3'(fi); fout_sel = 3'(fo);
    for (int p = 0; p < 64; p++) begin
      sync_pos_i = 6'(p);
      #1;
      for (int c = 0; c < NCH; c++)
        check(req, code_of(c), model(p, int'(on_pos[c*6 +: 6]), int'(off_pos[c*6 +: 6]),
                                     int'(target[c*5 +: 5]), fi, fo));
    end
  endtask

  task automatic t_reset;
    check("R11 pos", int'(tm_pos), 0);
    check("R11 done", int'(tm_done), 0);
  endtask

  task automatic t_manual;
    @(negedge clk);
    auto_en = 0; follow = 0; tick = 1;
    set_ch(0, 3, 9, 17); set_ch(1, 5, 5, 30); set_ch(2, 0, 1, 9);
    ch_en = 3'b101;
    repeat (5) @(negedge clk);
    check("R1 ch0", code_of(0), 17);
    check("R1 ch1 off", code_of(1), 0);
    check("R1 ch2", code_of(2), 9);
    check("R1 pos held", int'(tm_pos), 0);
  endtask

  task automatic t_window;
    @(negedge clk);
    auto_en = 1; follow = 1; ch_en = 3'b111; sync_done_i = 0;
    set_ch(0, 5, 20, 31); set_ch(1, 60, 4, 12); set_ch(2, 7, 7, 25);
    sweep("R4 window", 0, 0);
    sync_pos_i = 19; #1; check("R4 last lit", code_of(0), 31);
    sync_pos_i = 20; #1; check("R4 off edge", code_of(0), 0);
    sync_pos_i = 2;  #1; check("R4 wrap", code_of(1), 12);
  endtask

  task automatic t_fades;
    set_ch(0, 10, 40, 31); set_ch(1, 50, 10, 20); set_ch(2, 0, 30, 7);
    sweep("R5 R6 fade 3/2", 3, 2);
    sync_pos_i = 13; #1; check("R5 mid ramp", code_of(0), 15);
    sync_pos_i = 42; #1; check("R6 tail", code_of(0), 7);
    sweep("R5 R6 fade 6/1", 6, 1);
    sync_pos_i = 33; #1; check("R5 len48", code_of(0), 15);
    sweep("R5 R6 fade 7/5", 7, 5);
    sweep("R5 R6 fade 4/6", 4, 6);
    fin_sel = 0; fout_sel = 0;
  endtask

  task automatic t_gate_follow;
    set_ch(0, 0, 30, 22);
    sync_pos_i = 5; ch_en = 3'b110; #1;
    check("R7 gated", code_of(0), 0);
    ch_en = 3'b111; #1;
    check("R10 follow pos", code_of(0), 22);
    sync_done_i = 1; #1;
    check("R10 follow done", code_of(0), 0);
    sync_done_i = 0; #1;
  endtask

  task automatic measure(input string req, input int sel, input int exp);
    int cnt = 0;
    @(negedge clk);
    follow = 0; auto_en = 0; one_shot = 0; tick = 1; period_sel = 3'(sel);
    @(negedge clk); auto_en = 1;
    while (tm_pos != 1 && cnt < 500) begin @(negedge clk); cnt++; end
    cnt = 0;
    while (tm_pos == 1 && cnt < 500) begin @(negedge clk); cnt++; end
    check(req, cnt, exp);
    check({req, " step"}, int'(tm_pos), 2);
  endtask

  task automatic t_rate;
    measure("R2 rate sel0", 0, 1 << (BS + 0));
    measure("R2 rate sel2", 2, 1 << (BS + 2));
    measure("R3 sel6", 6, 1 << (BS + 5));
    measure("R3 sel7", 7, 1 << (BS + 5));
    @(negedge clk); tick = 0;
    begin
      int p0 = int'(tm_pos);
      repeat (200) @(negedge clk);
      check("R2 tick hold", int'(tm_pos), p0);
    end
    tick = 1;
  endtask

  task automatic t_oneshot;
    int cnt = 0;
    @(negedge clk);
    auto_en = 0; follow = 0; period_sel = 0; tick = 1; fin_sel = 0; fout_sel = 0;
    set_ch(0, 0, 10, 20); ch_en = 3'b001;
    @(negedge clk); auto_en = 1; one_shot = 1;
    while (!tm_done && cnt < 400) begin @(negedge clk); cnt++; end
    check("R8 frame length", (cnt >= 126 && cnt <= 130) ? 1 : 0, 1);
    check("R8 pos zero", int'(tm_pos), 0);
    check("R8 dark", code_of(0), 0);
    repeat (30) @(negedge clk);
    check("R8 still done", int'(tm_done), 1);
    check("R8 still dark", code_of(0), 0);
    one_shot = 0;
    @(negedge clk);
    check("R9 done cleared", int'(tm_done), 0);
    check("R9 restart lit", code_of(0), 20);
    check("R9 restart pos", int'(tm_pos), 0);
    one_shot = 1;
    cnt = 0;
    @(negedge clk);
    while (!tm_done && cnt < 400) begin @(negedge clk); cnt++; end
    auto_en = 0;
    @(negedge clk); auto_en = 1;
    @(negedge clk);
    check("R9 enable cycle clears", int'(tm_done), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_manual();
    t_window();
    t_fades();
    t_gate_follow();
    t_rate();
    t_oneshot();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule